// File: doc/BRIEF.md
# Gate-Driven ADSR Envelope Generator

This block produces the amplitude envelope for one synthesizer voice. It follows the familiar four segments (attack, decay, sustain, release) and a key-style gate drives it. While the gate is held, the envelope climbs from zero, falls back to a programmed sustain level and stays there. When the gate is released, the envelope fades to silence and the block reports that it is idle. The envelope word is meant to scale an oscillator's output in a downstream multiplier.

The caller supplies per-clock attack, decay and release step sizes and a sustain level, all as 32-bit unsigned values. The internal amplitude is a Q1.31 number that runs from 0.0 to 1.0, where full scale is 0x8000_0000. The output is a 16-bit Q2.14 word made of a zero sign bit followed by amplitude bits 31 to 17, so full scale reads 0x4000. The gate passes through a two-flop synchroniser and then an edge detector. Because of this, only a new key press restarts the envelope, and it can do so at any point in the envelope.

Top module: `adsr_gate_env`

## Requirements
- R1: The amplitude never exceeds full scale (0x8000_0000). In the output word, bit 15 is zero and bits 14..0 are amplitude bits 31..17. An attack step of 0x7FFF_FFFF therefore peaks at 0x3FFF.
- R2: After reset, the block is idle, `idle_o` is 1 and `env_o` is 0. A trigger passes through a one-cycle launch state, which clears the amplitude to zero, and the attack segment then starts from zero.
- R3: In attack, the attack step is added on every clock while the sum stays below full scale. When the sum would reach or exceed full scale, the amplitude is held and the block moves to decay.
- R4: In decay, the decay step is subtracted on every clock while the result stays above the sustain level. Otherwise, which includes a step larger than the amplitude, the amplitude is set to exactly the sustain level and the block enters sustain.
- R5: In sustain, the amplitude stays constant for as long as the gate stays high. When the gate goes low, the block enters release.
- R6: In release, the release step is subtracted on every clock while the amplitude is greater than the step. After that, the block returns to idle with the amplitude at zero.
- R7: The gate is synchronised through two flops. A rising edge of the gate, seen in any state, sends the block through launch and restarts the envelope from zero. A gate held high causes no further restarts. The first response on `idle_o` comes three clock edges after the gate changes.
- R8: If the gate goes low during attack or decay, the block goes straight to release and starts from the amplitude it has reached.
- R9: An attack step of 0xFFFF_FFFF forces `env_o` to 0x4000. An attack step of 0 forces `env_o` to 0. Both overrides apply in every state.
- R10: `idle_o` is high in the idle state and only in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| gate_i | input | 1 | Key gate, asynchronous to the clock |
| atk_step_i | input | 32 | Amount added per clock in attack; all ones and zero are reserved codes |
| dec_step_i | input | 32 | Amount subtracted per clock in decay |
| rel_step_i | input | 32 | Amount subtracted per clock in release |
| sus_lvl_i | input | 32 | Sustain amplitude, Q1.31 |
| env_o | output | 16 | Envelope, Q2.14 |
| idle_o | output | 1 | High while no envelope is active |

## Verification
The hardest case to reach is a restart while a key is held: the gate is already high, so a new rising edge needs a low pulse on the gate. A one-cycle low pulse is also long enough for the synchroniser to move the block out of sustain into release before the restart edge arrives. The bench applies exactly such a one-cycle dip during sustain. It checks that the output keeps the sustain level through the one release cycle, then drops to zero in attack and climbs by one step. Step values are chosen so that every segment lasts only a few cycles, which lets each transition be checked against a cycle count worked out by hand.

// File: rtl/adsr_gate_env.sv
module adsr_gate_env #(
  parameter int AMP_W = 32,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             gate_i,
  input  logic [AMP_W-1:0] atk_step_i,
  input  logic [AMP_W-1:0] dec_step_i,
  input  logic [AMP_W-1:0] rel_step_i,
  input  logic [AMP_W-1:0] sus_lvl_i,
  output logic [OUT_W-1:0] env_o,
  output logic             idle_o
);
  localparam logic [AMP_W:0]   FULL    = {2'b01, {(AMP_W-1){1'b0}}};
  localparam logic [AMP_W-1:0] ALL_ONE = '1;
  localparam logic [OUT_W-1:0] OUT_ONE = {2'b01, {(OUT_W-2){1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_LAUNCH, S_ATK, S_DEC, S_SUS, S_REL} st_t;

  st_t              st_q, st_d;
  logic [AMP_W-1:0] amp_q, amp_d;
  logic             g1_q, g2_q, g3_q;
  logic             rise, held;
  logic [AMP_W:0]   atk_sum, dec_dif;

  always_ff @(posedge clk_i or posedge rst_i)
    if (rst_i) {g1_q, g2_q, g3_q} <= '0;
    else       {g1_q, g2_q, g3_q} <= {gate_i, g1_q, g2_q};

  assign held    = g2_q;
  assign rise    = g2_q & ~g3_q;
  assign atk_sum = {1'b0, amp_q} + {1'b0, atk_step_i};
  assign dec_dif = {1'b0, amp_q} - {1'b0, dec_step_i};

  always_comb begin
    st_d  = st_q;
    amp_d = amp_q;
    if (rise && st_q != S_LAUNCH) st_d = S_LAUNCH;
    else begin
      case (st_q)
        S_IDLE: ;
        S_LAUNCH: begin
          amp_d = '0;
          st_d  = S_ATK;
        end
        S_ATK:
          if (!held)             st_d = S_REL;
          else if (atk_sum < FULL) amp_d = atk_sum[AMP_W-1:0];
          else                   st_d = S_DEC;
        S_DEC:
          if (!held) st_d = S_REL;
          else if (!dec_dif[AMP_W] && dec_dif[AMP_W-1:0] > sus_lvl_i)
            amp_d = dec_dif[AMP_W-1:0];
          else begin
            amp_d = sus_lvl_i;
            st_d  = S_SUS;
          end
        S_SUS:
          if (!held) st_d = S_REL;
        S_REL:
          if (amp_q > rel_step_i) amp_d = amp_q - rel_step_i;
          else begin
            amp_d = '0;
            st_d  = S_IDLE;
          end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or posedge rst_i)
    if (rst_i) begin
      st_q  <= S_IDLE;
      amp_q <= '0;
    end else begin
      st_q  <= st_d;
      amp_q <= amp_d;
    end

  assign idle_o = (st_q == S_IDLE);
  assign env_o  = (atk_step_i == ALL_ONE) ? OUT_ONE :
                  (atk_step_i == '0)      ? '0 :
                  {1'b0, amp_q[AMP_W-1 -: OUT_W-1]};

  AST_AMP_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    {1'b0, amp_q} <= FULL); // R1
  AST_LAUNCH_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    st_q == S_LAUNCH |=> st_q == S_ATK && amp_q == '0); // R2
  AST_ATTACK_CLIMB: assert property (@(posedge clk_i) disable iff (rst_i)
    st_q == S_ATK && !rise && held && atk_step_i != '0 |=> amp_q > $past(amp_q) || st_q == S_DEC); // R3
  AST_DECAY_CLAMP: assert property (@(posedge clk_i) disable iff (rst_i)
    st_q == S_DEC ##1 st_q == S_SUS |-> amp_q == $past(sus_lvl_i)); // R4
  AST_SUSTAIN_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    st_q == S_SUS && held && !rise |=> $stable(amp_q)); // R5
  AST_RELEASE_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    st_q == S_REL && !rise && rel_step_i != '0 |=> amp_q < $past(amp_q) || st_q == S_IDLE); // R6
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
    idle_o && atk_step_i != ALL_ONE |-> env_o == '0); // R6
  AST_EDGE_RELAUNCH: assert property (@(posedge clk_i) disable iff (rst_i)
    rise |=> st_q == S_LAUNCH); // R7
endmodule

// File: tb/adsr_gate_env_tb_top.sv
module adsr_gate_env_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        gate;
  logic [31:0] atk, dec, rel, sus;
  logic [15:0] env;
  logic        idle;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  adsr_gate_env dut_i (
    .clk_i(clk), .rst_i(rst), .gate_i(gate),
    .atk_step_i(atk), .dec_step_i(dec), .rel_step_i(rel), .sus_lvl_i(sus),
    .env_o(env), .idle_o(idle)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle_idle();
    gate = 1'b0;
    tick(3);
    for (int i = 0; i < 200 && !idle; i++) tick(1);
    chk("R6 idle reached", idle, 1);
  endtask

  task automatic t_reset();
    chk("R2 reset idle_o", idle, 1);
    chk("R2 reset env", env, 0);
  endtask

  task automatic t_full_cycle();
    atk = 32'h1000_0000; dec = 32'h0800_0000; sus = 32'h4000_0000; rel = 32'h1000_0000;
    gate = 1'b1;
    tick(2);
    chk("R7 sync latency idle", idle, 1);
    tick(1);
    chk("R10 active idle_o", idle, 0);
    tick(1);
    chk("R2 attack starts at zero", env, 0);
    tick(1);
    chk("R3 first attack step", env, 16'h0800);
    tick(6);
    chk("R3 attack peak", env, 16'h3800);
    tick(1);
    chk("R3 held at decay entry", env, 16'h3800);
    tick(5);
    chk("R4 last decay step", env, 16'h2400);
    tick(1);
    chk("R4 clamped to sustain", env, 16'h2000);
    tick(50);
    chk("R5 sustain holds, R7 no relaunch", env, 16'h2000);
    chk("R10 idle_o low in sustain", idle, 0);
    gate = 1'b0;
    tick(3);
    chk("R6 release entry keeps level", env, 16'h2000);
    tick(1);
    chk("R6 first release step", env, 16'h1800);
    tick(2);
    chk("R6 last release step", env, 16'h0800);
    tick(1);
    chk("R6 back to idle", idle, 1);
    chk("R6 idle env zero", env, 0);
  endtask

  task automatic t_relaunch_sustain();
    gate = 1'b1;
    tick(25);
    chk("R5 in sustain", env, 16'h2000);
    gate = 1'b0;
    tick(1);
    gate = 1'b1;
    tick(3);
    chk("R7 level before relaunch", env, 16'h2000);
    tick(1);
    chk("R7 relaunch clears", env, 0);
    chk("R7 not idle", idle, 0);
    tick(1);
    chk("R7 restarted attack", env, 16'h0800);
    settle_idle();
  endtask

  task automatic t_drop_in_attack();
    gate = 1'b1;
    tick(6);
    gate = 1'b0;
    tick(3);
    chk("R8 release from attack level", env, 16'h2000);
    chk("R8 still active", idle, 0);
    tick(1);
    chk("R8 release step", env, 16'h1800);
    tick(3);
    chk("R8 idle after release", idle, 1);
  endtask

  task automatic t_saturate();
    atk = 32'h7FFF_FFFF; dec = 32'hFFFF_0000; sus = 32'h2000_0000; rel = 32'h1000_0000;
    gate = 1'b1;
    tick(5);
    chk("R1 peak below full scale", env, 16'h3FFF);
    tick(1);
    chk("R1 held at peak", env, 16'h3FFF);
    tick(1);
    chk("R4 oversize decay step clamps", env, 16'h1000);
    settle_idle();
  endtask

  task automatic t_bypass();
    atk = 32'hFFFF_FFFF;
    tick(1);
    chk("R9 bypass in idle", env, 16'h4000);
    atk = 32'h0;
    gate = 1'b1;
    tick(10);
    chk("R9 zero code silences", env, 0);
    chk("R9 zero code still active", idle, 0);
    settle_idle();
  endtask

  initial begin
    rst = 1'b1; gate = 1'b0;
    atk = 32'h1000_0000; dec = 32'h0800_0000; sus = 32'h4000_0000; rel = 32'h1000_0000;
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_full_cycle();
    t_relaunch_sustain();
    t_drop_in_attack();
    t_saturate();
    t_bypass();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule